// File: doc/BRIEF.md
# Multi-ratio clock divider with glitch-free output gating

The block takes one fast timing clock and derives seven families of board clocks from it: processor, memory, 66 MHz, PCI, interrupt-controller, 48 MHz and reference. The input clock is the half-period tick. An output with ratio N is high for N input cycles and low for N input cycles, so every output has 50 % duty cycle. This also lets the divide-by-one reference in test mode toggle on every tick. All dividers restart together after a mode change. Their rising edges therefore line up on a common phase.

Two mode pins choose how the outputs run. Mode 11 is the fast host mode and mode 10 is the slow host mode. Mode 01 divides the input, which is overdriven by a tester, by fixed ratios. Mode 00 floats the processor, memory and PCI drivers. An active-low power-down input stops every output low. Each output copy has its own enable bit from an external register bank. A disabled copy sits low, and both enable and power-down changes only take effect while the affected waveform is low.

The reference pin is shared. After reset it is an undriven input for a parameterised settling count. Its level is then latched as a strap that picks the interrupt-controller rate, and from then on the pin drives the reference clock.

Top module: `clkgen_top`

## Requirements
- R1: While rst_ni is low, every clock output is low and ref_oe_o is 0.
- R2: After reset release, ref_oe_o stays 0 for STRAP_SETTLE cycles. It then goes to 1 and stays 1, ref_pad_i is latched as the strap, and ref_o starts toggling.
- R3: With sel_i = 2'b11, the half-period counts in input cycles are processor 2, memory 2, 66 MHz 3, PCI 6, 48 MHz DIV_USB and reference DIV_REF.
- R4: With sel_i = 2'b10, the processor half-period is 3. Memory stays at 2 and PCI stays at 6.
- R5: With sel_i = 2'b01, the half-periods are processor 2, memory 2, 66 MHz 3, PCI 6, interrupt-controller 6, 48 MHz 2 and reference 1.
- R6: With sel_i = 2'b00, cpu_oe_o, sdram_oe_o and pci_oe_o are 0 and the other outputs keep running at their sel_i = 2'b11 rates. In every other mode those three are 1.
- R7: A latched strap of 1 gives the interrupt-controller clock the PCI half-period. A strap of 0 gives it twice the PCI half-period. In test mode it is 6 regardless of the strap. Its rising edges always fall on PCI rising edges.
- R8: After a mode change, all dividers restart from a common phase. Every PCI rising edge coincides with a processor rising edge and a 66 MHz rising edge.
- R9: An enable bit of 0 holds that output copy low while sibling copies keep toggling. An enable bit of 1 lets the copy run.
- R10: Enable changes take effect only while the waveform is low, so every high pulse on an output has the full half-period width.
- R11: With pd_ni low, every clock output stops low once its current high phase ends. The output-enable signals are unchanged. Raising pd_ni resumes the outputs at their mode rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast timing clock (half-period tick) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2 | Mode pins, synchronised inside |
| pd_ni | input | 1 | Active-low power-down, synchronised inside |
| ref_pad_i | input | 1 | Sampled level of the shared reference/strap pin |
| cpu_en_i | input | N_CPU | Processor clock copy enables |
| sdram_en_i | input | N_SDRAM | Memory clock copy enables |
| m66_en_i | input | N_M66 | 66 MHz clock copy enables |
| pci_en_i | input | N_PCI | PCI clock copy enables |
| apic_en_i | input | N_APIC | Interrupt-controller clock copy enables |
| usb_en_i | input | N_USB | 48 MHz clock copy enables |
| cpu_o | output | N_CPU | Processor clocks |
| cpu_oe_o | output | 1 | Processor driver enable |
| sdram_o | output | N_SDRAM | Memory clocks |
| sdram_oe_o | output | 1 | Memory driver enable |
| m66_o | output | N_M66 | 66 MHz clocks |
| pci_o | output | N_PCI | PCI clocks |
| pci_oe_o | output | 1 | PCI driver enable |
| apic_o | output | N_APIC | Interrupt-controller clocks |
| usb_o | output | N_USB | 48 MHz clocks |
| ref_o | output | 1 | Reference clock driven onto the shared pin |
| ref_oe_o | output | 1 | Shared-pin driver enable |

## Verification
A divider counter that is wrong appears within one output period as a high or low phase of the wrong length. A lost common restart appears at the next PCI rising edge, because the processor or 66 MHz edge is then missing. A gate register that updates mid-pulse appears at once as a shortened high pulse. A wrong strap latch first appears as an early ref_oe_o rise during settling, and later as an interrupt-controller period that is wrong by a factor of two.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  typedef enum logic [1:0] {
    MODE_HIZ  = 2'b00,
    MODE_TEST = 2'b01,
    MODE_LO   = 2'b10,
    MODE_HI   = 2'b11
  } mode_e;

  localparam int G_CPU  = 0;
  localparam int G_SDR  = 1;
  localparam int G_M66  = 2;
  localparam int G_PCI  = 3;
  localparam int G_APIC = 4;
  localparam int G_USB  = 5;
  localparam int G_REF  = 6;
  localparam int NGRP   = 7;
endpackage

// File: rtl/clkgen_sync.sv
module clkgen_sync #(
  parameter int             W      = 1,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   RST    = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clkgen_strap.sv
module clkgen_strap #(
  parameter int SETTLE = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pad_i,
  output logic strap_o,
  output logic oe_o,
  output logic latch_o
);
  localparam int SW = $clog2(SETTLE + 1);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      strap_o <= 1'b1;
      oe_o    <= 1'b0;
      latch_o <= 1'b0;
    end else begin
      latch_o <= 1'b0;
      if (!oe_o) begin
        if (cnt_q == SW'(SETTLE)) begin
          strap_o <= pad_i;
          oe_o    <= 1'b1;
          latch_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + SW'(1);
        end
      end
    end
  end

  assert_no_early_drive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q < SW'(SETTLE)) |-> !oe_o);

  assert_oe_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(oe_o) |-> oe_o);
endmodule

// File: rtl/clkgen_div.sv
module clkgen_div #(
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [DW-1:0] half_i,
  output logic          wave_o
);
  localparam int CW = DW + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = {half_i, 1'b0} - CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wave_o <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      wave_o <= 1'b0;
    end else begin
      wave_o <= (cnt_q < {1'b0, half_i});
      cnt_q  <= (cnt_q >= last) ? '0 : cnt_q + CW'(1);
    end
  end

  assert_restart_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !wave_o);
endmodule

// File: rtl/clkgen_gate.sv
module clkgen_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wave_i,
  input  logic en_i,
  output logic clk_o
);
  logic g_q;

  // enable only moves while the waveform is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      g_q <= 1'b0;
    else if (!wave_i) g_q <= en_i;
  end

  assign clk_o = wave_i & g_q;

  assert_rise_with_wave_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o) |-> $rose(wave_i));

  assert_fall_with_wave_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_o) |-> $fell(wave_i));

  assert_off_stays_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wave_i) |=> !clk_o);
endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
  import clkgen_pkg::*;
#(
  parameter int N_CPU        = 3,
  parameter int N_SDRAM      = 9,
  parameter int N_M66        = 2,
  parameter int N_PCI        = 8,
  parameter int N_APIC       = 2,
  parameter int N_USB        = 2,
  parameter int DIV_USB      = 4,
  parameter int DIV_REF      = 14,
  parameter int STRAP_SETTLE = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         sel_i,
  input  logic               pd_ni,
  input  logic               ref_pad_i,
  input  logic [N_CPU-1:0]   cpu_en_i,
  input  logic [N_SDRAM-1:0] sdram_en_i,
  input  logic [N_M66-1:0]   m66_en_i,
  input  logic [N_PCI-1:0]   pci_en_i,
  input  logic [N_APIC-1:0]  apic_en_i,
  input  logic [N_USB-1:0]   usb_en_i,
  output logic [N_CPU-1:0]   cpu_o,
  output logic               cpu_oe_o,
  output logic [N_SDRAM-1:0] sdram_o,
  output logic               sdram_oe_o,
  output logic [N_M66-1:0]   m66_o,
  output logic [N_PCI-1:0]   pci_o,
  output logic               pci_oe_o,
  output logic [N_APIC-1:0]  apic_o,
  output logic [N_USB-1:0]   usb_o,
  output logic               ref_o,
  output logic               ref_oe_o
);
  localparam int MAXA = (DIV_USB > 12) ? DIV_USB : 12;
  localparam int MAXN = (DIV_REF > MAXA) ? DIV_REF : MAXA;
  localparam int DW   = $clog2(MAXN + 1);

  localparam int O_CPU  = 0;
  localparam int O_SDR  = O_CPU + N_CPU;
  localparam int O_M66  = O_SDR + N_SDRAM;
  localparam int O_PCI  = O_M66 + N_M66;
  localparam int O_APIC = O_PCI + N_PCI;
  localparam int O_USB  = O_APIC + N_APIC;
  localparam int O_REF  = O_USB + N_USB;
  localparam int NT     = O_REF + 1;

  function automatic int grp_of(int i);
    if (i < O_SDR)  return G_CPU;
    if (i < O_M66)  return G_SDR;
    if (i < O_PCI)  return G_M66;
    if (i < O_APIC) return G_PCI;
    if (i < O_USB)  return G_APIC;
    if (i < O_REF)  return G_USB;
    return G_REF;
  endfunction

  logic [1:0]      sel_q;
  logic            pd_run;
  mode_e           mode_r;
  logic            strap, strap_oe, strap_latch;
  logic            restart;
  logic [DW-1:0]   half [NGRP];
  logic [NGRP-1:0] wave;
  logic [NT-1:0]   en_all;
  logic [NT-1:0]   out_all;

  clkgen_sync #(.W(2), .STAGES(SYNC_STAGES), .RST(2'b11)) u_sel_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sel_i), .q_o(sel_q)
  );

  clkgen_sync #(.W(1), .STAGES(SYNC_STAGES), .RST(1'b1)) u_pd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pd_ni), .q_o(pd_run)
  );

  clkgen_strap #(.SETTLE(STRAP_SETTLE)) u_strap (
    .clk_i(clk_i), .rst_ni(rst_ni), .pad_i(ref_pad_i),
    .strap_o(strap), .oe_o(strap_oe), .latch_o(strap_latch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_r <= MODE_HI;
    else         mode_r <= mode_e'(sel_q);
  end

  // a new mode or a freshly latched strap realigns every divider
  assign restart = (mode_e'(sel_q) != mode_r) | strap_latch;

  always_comb begin
    half[G_SDR] = DW'(2);
    half[G_M66] = DW'(3);
    half[G_PCI] = DW'(6);
    if (mode_r == MODE_TEST) begin
      half[G_CPU]  = DW'(2);
      half[G_APIC] = DW'(6);
      half[G_USB]  = DW'(2);
      half[G_REF]  = DW'(1);
    end else begin
      half[G_CPU]  = (mode_r == MODE_LO) ? DW'(3) : DW'(2);
      half[G_APIC] = strap ? DW'(6) : DW'(12);
      half[G_USB]  = DW'(DIV_USB);
      half[G_REF]  = DW'(DIV_REF);
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_div
    clkgen_div #(.DW(DW)) u_div (
      .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart),
      .half_i(half[g]), .wave_o(wave[g])
    );
  end

  assign en_all = {strap_oe, usb_en_i, apic_en_i, pci_en_i, m66_en_i, sdram_en_i, cpu_en_i};

  for (genvar i = 0; i < NT; i++) begin : g_out
    localparam int GI = grp_of(i);
    clkgen_gate u_gate (
      .clk_i(clk_i), .rst_ni(rst_ni), .wave_i(wave[GI]),
      .en_i(en_all[i] & pd_run), .clk_o(out_all[i])
    );
  end

  assign cpu_o   = out_all[O_SDR-1:O_CPU];
  assign sdram_o = out_all[O_M66-1:O_SDR];
  assign m66_o   = out_all[O_PCI-1:O_M66];
  assign pci_o   = out_all[O_APIC-1:O_PCI];
  assign apic_o  = out_all[O_USB-1:O_APIC];
  assign usb_o   = out_all[O_REF-1:O_USB];
  assign ref_o   = out_all[O_REF];
  assign ref_oe_o = strap_oe;

  assign cpu_oe_o   = (mode_r != MODE_HIZ);
  assign sdram_oe_o = (mode_r != MODE_HIZ);
  assign pci_oe_o   = (mode_r != MODE_HIZ);

  assert_apic_sync_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wave[G_APIC]) |-> $rose(wave[G_PCI]));

  assert_pci_cpu_phase_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wave[G_PCI]) |-> $rose(wave[G_CPU]) && $rose(wave[G_M66]));
endmodule

// File: tb/clkgen_top_test.sv
module clkgen_top_test;
  localparam int SETTLE = 32;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] sel_i = 2'b11;
  logic       pd_ni = 1'b1;
  logic       ref_pad_i = 1'b1;
  logic [2:0] cpu_en_i = '1;
  logic [8:0] sdram_en_i = '1;
  logic [1:0] m66_en_i = '1;
  logic [7:0] pci_en_i = '1;
  logic [1:0] apic_en_i = '1;
  logic [1:0] usb_en_i = '1;
  logic [2:0] cpu_o;
  logic [8:0] sdram_o;
  logic [1:0] m66_o;
  logic [7:0] pci_o;
  logic [1:0] apic_o;
  logic [1:0] usb_o;
  logic cpu_oe_o, sdram_oe_o, pci_oe_o, ref_o, ref_oe_o;

  always #5 clk_i = ~clk_i;

  clkgen_top #(.STRAP_SETTLE(SETTLE)) uut (
    .clk_i, .rst_ni, .sel_i, .pd_ni, .ref_pad_i,
    .cpu_en_i, .sdram_en_i, .m66_en_i, .pci_en_i, .apic_en_i, .usb_en_i,
    .cpu_o, .cpu_oe_o, .sdram_o, .sdram_oe_o, .m66_o, .pci_o, .pci_oe_o,
    .apic_o, .usb_o, .ref_o, .ref_oe_o
  );

  // monitored copies: 0 cpu,1 sdram,2 m66,3 pci,4 apic,5 usb,6 ref
  logic [6:0] mon;
  assign mon = {ref_o, usb_o[0], apic_o[0], pci_o[0], m66_o[0], sdram_o[0], cpu_o[0]};

  typedef struct {int idx; int n; string tag;} exp_t;
  exp_t sb_q[$];
  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_exp(input int idx, input int n, input string tag);
    exp_t e;
    e.idx = idx; e.n = n; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic measure(input int idx, output int hi, output int lo);
    int t;
    logic prev;
    hi = 0; lo = 0; t = 0;
    do begin
      prev = mon[idx];
      @(negedge clk_i);
      t++;
    end while (!(prev == 1'b0 && mon[idx] == 1'b1) && t < 400);
    while (mon[idx] == 1'b1 && hi < 400) begin hi++; @(negedge clk_i); end
    while (mon[idx] == 1'b0 && lo < 400) begin lo++; @(negedge clk_i); end
  endtask

  task automatic run_scoreboard();
    exp_t e;
    int hi, lo;
    while (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      measure(e.idx, hi, lo);
      chk(hi == e.n, {e.tag, " high"}, hi, e.n);
      chk(lo == e.n, {e.tag, " low"}, lo, e.n);
    end
  endtask

  task automatic check_align(input string tag);
    logic pp, pc;
    int t;
    t = 0;
    @(negedge clk_i);
    do begin
      pp = mon[3]; pc = mon[0];
      @(negedge clk_i);
      t++;
    end while (!(pp == 1'b0 && mon[3] == 1'b1) && t < 400);
    chk(pc == 1'b0 && mon[0] == 1'b1 && mon[2] == 1'b1, tag, {30'd0, mon[0], mon[2]}, 3);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  // pulse-width monitor for the no-runt check
  logic win = 1'b0;
  int   hl = 0, rerr = 0, npulse = 0;
  always @(negedge clk_i) begin
    if (win) begin
      if (m66_o[0]) hl++;
      else if (hl != 0) begin
        if (hl != 3) rerr++;
        npulse++;
        hl = 0;
      end
    end else hl = 0;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int zc;
    bit seen;
    // R1 reset state
    repeat (5) @(negedge clk_i);
    chk(mon == 7'd0 && ref_oe_o == 1'b0, "R1 reset", {24'd0, mon, ref_oe_o}, 0);
    rst_ni = 1'b1;
    // R2 strap window
    repeat (SETTLE - 2) @(negedge clk_i);
    chk(ref_oe_o == 1'b0, "R2 pad undriven while settling", ref_oe_o, 0);
    repeat (8) @(negedge clk_i);
    chk(ref_oe_o == 1'b1, "R2 pad driven after settle", ref_oe_o, 1);

    // R3 fast host mode, R7 strap=1
    push_exp(0, 2, "R3 cpu");  push_exp(1, 2, "R3 sdram");
    push_exp(2, 3, "R3 m66");  push_exp(3, 6, "R3 pci");
    push_exp(4, 6, "R7 apic strap1");
    push_exp(5, 4, "R3 usb");  push_exp(6, 14, "R2 R3 ref");
    run_scoreboard();
    chk(cpu_oe_o && sdram_oe_o && pci_oe_o, "R6 oe on in mode 11", {29'd0, cpu_oe_o, sdram_oe_o, pci_oe_o}, 7);
    check_align("R8 align mode 11");

    // R4 slow host
    sel_i = 2'b10;
    repeat (10) @(negedge clk_i);
    push_exp(0, 3, "R4 cpu"); push_exp(1, 2, "R4 sdram"); push_exp(3, 6, "R4 pci");
    run_scoreboard();
    check_align("R8 align mode 10");

    // R5 test mode
    sel_i = 2'b01;
    repeat (10) @(negedge clk_i);
    push_exp(0, 2, "R5 cpu");  push_exp(1, 2, "R5 sdram");
    push_exp(2, 3, "R5 m66");  push_exp(3, 6, "R5 pci");
    push_exp(4, 6, "R5 apic"); push_exp(5, 2, "R5 usb");
    push_exp(6, 1, "R5 ref");
    run_scoreboard();
    check_align("R8 align test mode");

    // R6 float mode
    sel_i = 2'b00;
    repeat (10) @(negedge clk_i);
    chk(!cpu_oe_o && !sdram_oe_o && !pci_oe_o, "R6 oe off in mode 00", {29'd0, cpu_oe_o, sdram_oe_o, pci_oe_o}, 0);
    push_exp(2, 3, "R6 m66"); push_exp(5, 4, "R6 usb"); push_exp(6, 14, "R6 ref");
    run_scoreboard();

    // R9 per-copy enable
    sel_i = 2'b11;
    repeat (10) @(negedge clk_i);
    cpu_en_i[0] = 1'b0;
    repeat (10) @(negedge clk_i);
    zc = 0; seen = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_i);
      if (cpu_o[0]) zc++;
      if (cpu_o[1]) seen = 1;
    end
    chk(zc == 0, "R9 disabled copy low", zc, 0);
    chk(seen, "R9 sibling copy runs", seen, 1);
    cpu_en_i[0] = 1'b1;
    push_exp(0, 2, "R9 re-enabled cpu");
    run_scoreboard();

    // R10 enable toggles at every phase
    while (m66_o[0]) @(negedge clk_i);
    win = 1'b1;
    for (int k = 0; k < 24; k++) begin
      repeat ((k % 7) + 1) @(negedge clk_i);
      m66_en_i[0] = ~m66_en_i[0];
    end
    m66_en_i[0] = 1'b1;
    repeat (30) @(negedge clk_i);
    win = 1'b0;
    chk(rerr == 0, "R10 runt pulses", rerr, 0);
    chk(npulse > 0, "R10 pulses observed", npulse, 1);

    // R11 power-down
    pd_ni = 1'b0;
    repeat (30) @(negedge clk_i);
    zc = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_i);
      if (cpu_o != 0 || sdram_o != 0 || m66_o != 0 || pci_o != 0 ||
          apic_o != 0 || usb_o != 0 || ref_o) zc++;
    end
    chk(zc == 0, "R11 outputs low in power-down", zc, 0);
    chk(ref_oe_o && cpu_oe_o, "R11 oe unchanged", {30'd0, ref_oe_o, cpu_oe_o}, 3);
    pd_ni = 1'b1;
    push_exp(3, 6, "R11 pci resumes"); push_exp(0, 2, "R11 cpu resumes");
    run_scoreboard();

    // R7 strap=0
    rst_ni = 1'b0;
    ref_pad_i = 1'b0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (SETTLE + 8) @(negedge clk_i);
    chk(ref_oe_o == 1'b1, "R2 pad driven after second settle", ref_oe_o, 1);
    push_exp(4, 12, "R7 apic strap0"); push_exp(3, 6, "R7 pci strap0");
    run_scoreboard();
    sel_i = 2'b01;
    repeat (10) @(negedge clk_i);
    push_exp(4, 6, "R7 apic test mode strap0");
    run_scoreboard();

    summary();
    $finish;
  end
endmodule